// File: doc/BRIEF.md
# SPI Memory-Card Exchange Controller

This block is a register-programmed SPI master for a memory card run in SPI mode. A host programs a control register, an exchange byte count and a soft-reset register over a simple single-cycle register port. It pushes outgoing bytes into an 8-byte transmit queue and pops incoming bytes from an 8-byte receive queue. Each exchange runs in one direction only. In send mode the block shifts queued bytes out on MOSI. In receive mode it clocks bytes in from MISO while holding MOSI high.

The block counts finished bytes against the programmed count and raises three sticky status flags: exchange done, transmit queue drained and receive queue full. A masked OR of the flags drives an interrupt. If the receive queue fills before the count is reached, the block stops the serial clock. It resumes only after the host drains the queue and writes the start bit again. Card command meaning, CRC and response parsing are left to host software.

Top module: `spi_xchg_top`

## Requirements
- R1: After reset, csN is 1, sck is 0, mosi is 1 and irq is 0. A status read returns 0 in bits 2:0. The control register (address 0) resets to 0x0004.
- R2: csN follows bit 2 of the control register. Writing 0 to that bit drives csN low and writing 1 drives it high.
- R3: With divisor N in control bits 15:8, sck has a period of 2*(N+1) clk cycles within a byte. sck stays low whenever no byte is in flight.
- R4: In send mode (control bit 1 = 0), each byte written to address 3 goes out MSB first. MOSI is stable while sck is high and is valid at each rising sck edge.
- R5: A send exchange moves exactly the count written to address 1, taking bytes from the transmit queue in order. When the last counted byte completes, status bit 0 (done) is set. Status bit 1 is set when a byte completes and leaves the transmit queue empty.
- R6: In receive mode (control bit 1 = 1), MISO is sampled on the rising sck edge, MSB first, and each byte is pushed into the receive queue (read at address 4) in arrival order. mosi stays 1 throughout.
- R7: Once the byte count is reached, no further sck edges occur even while the start bit stays 1.
- R8: If the receive queue (8 deep) is full while count bytes are still owed, status bit 2 is set and sck stops. After the host pops the queue and writes the control register with bit 0 = 1, the exchange resumes and delivers the remaining bytes.
- R9: irq is the OR of status bits 0, 1 and 2, each ANDed with its enable in control bits 3, 4 and 5.
- R10: Reading the status register (address 5) returns the flags and clears bits 2:0. A flag set in the same cycle as the read survives.
- R11: Writing 0 to address 2 clears the byte, bit and divider counters and the receive stall, so the next exchange starts from byte 0. Writing a nonzero value there has no effect.
- R12: With control bit 0 (start) at 0, no exchange begins and sck stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (triggers pop and status clear) |
| regAddr | input | 3 | Register address |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data for regAddr (combinational) |
| sck | output | 1 | Serial clock to card |
| mosi | output | 1 | Serial data to card |
| miso | input | 1 | Serial data from card |
| csN | output | 1 | Card select, active low |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that the host changes neither the mode bit nor the divisor while a byte is in flight. They also assume that the host writes the control register only when sck is low, because a mode change mid-byte would move MOSI while sck is high. The stimulus follows the host protocol: it clears the start bit and writes the soft reset before it reprograms the count or the mode, and it rewrites start only while the exchange is stalled or finished. The card model changes MISO only after falling sck edges, so the value the block samples is settled well before the next rising edge.

// File: rtl/spi_xchg_pkg.sv
package spi_xchg_pkg;
  localparam int REG_W  = 16;
  localparam int BYTE_W = 8;

  localparam logic [2:0] ADDR_CTRL  = 3'd0;
  localparam logic [2:0] ADDR_COUNT = 3'd1;
  localparam logic [2:0] ADDR_SRST  = 3'd2;
  localparam logic [2:0] ADDR_TXD   = 3'd3;
  localparam logic [2:0] ADDR_RXD   = 3'd4;
  localparam logic [2:0] ADDR_STAT  = 3'd5;

  // per-cycle commands from control to datapath
  typedef struct packed {
    logic load;    // pop tx queue into shift register
    logic sample;  // capture miso (rising sck)
    logic shift;   // advance tx shift register (falling sck)
    logic push;    // write completed rx byte into rx queue
  } xchgStrobe_t;
endpackage

// File: rtl/spi_xchg_fifo.sv
module spi_xchg_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   FULLCNT = (AW + 1)'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [AW:0]   count;
  logic doPush, doPop;

  assign doPush  = push && !full;
  assign doPop   = pop && !empty;
  assign empty   = (count == '0);
  assign full    = (count == FULLCNT);
  assign popData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spi_xchg_dp.sv
module spi_xchg_dp
  import spi_xchg_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  xchgStrobe_t       stb,
  input  logic              modeRecv,
  input  logic              miso,
  input  logic              txPush,
  input  logic [BYTE_W-1:0] txData,
  input  logic              rxPop,
  output logic              mosi,
  output logic [BYTE_W-1:0] rxData,
  output logic              txEmpty,
  output logic              txFull,
  output logic              rxEmpty,
  output logic              rxFull
);
  logic [BYTE_W-1:0] txHead, txShift, rxShift;

  spi_xchg_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_txq (
    .clk(clk), .rstN(rstN), .push(txPush), .pushData(txData),
    .pop(stb.load), .popData(txHead), .empty(txEmpty), .full(txFull)
  );

  spi_xchg_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_rxq (
    .clk(clk), .rstN(rstN), .push(stb.push), .pushData(rxShift),
    .pop(rxPop), .popData(rxData), .empty(rxEmpty), .full(rxFull)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '1;
      rxShift <= '0;
    end else begin
      if (stb.load)        txShift <= txHead;
      else if (stb.shift)  txShift <= {txShift[BYTE_W-2:0], 1'b1};
      if (stb.sample)      rxShift <= {rxShift[BYTE_W-2:0], miso};
    end
  end

  assign mosi = modeRecv ? 1'b1 : txShift[BYTE_W-1];
endmodule

// File: rtl/spi_xchg_ctrl.sv
module spi_xchg_ctrl
  import spi_xchg_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [2:0]        regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  logic [BYTE_W-1:0] rxData,
  input  logic              txEmpty,
  input  logic              txFull,
  input  logic              rxEmpty,
  input  logic              rxFull,
  output xchgStrobe_t       stb,
  output logic              modeRecv,
  output logic              txPush,
  output logic [BYTE_W-1:0] txData,
  output logic              rxPop,
  output logic              sck,
  output logic              csN,
  output logic              irq
);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} phase_e;

  logic [REG_W-1:0] ctrlReg;
  logic [CNT_W-1:0] xchgCount, byteCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [DIV_W-1:0] divCnt, divisor;
  logic [2:0]       stat, statSet, statEn;
  logic             rxHalt, sckR;
  phase_e           phase;

  logic startBit, wrCtrl, softClr, restart, rdStat;
  logic owed, canRun, stallNow, halfDone, byteEnd;

  assign startBit = ctrlReg[0];
  assign modeRecv = ctrlReg[1];
  assign csN      = ctrlReg[2];
  assign statEn   = ctrlReg[5:3];
  assign divisor  = ctrlReg[8 +: DIV_W];

  assign wrCtrl  = regWe && (regAddr == ADDR_CTRL);
  assign softClr = regWe && (regAddr == ADDR_SRST) && (regWdata == '0);
  assign restart = wrCtrl && regWdata[0];
  assign rdStat  = regRe && (regAddr == ADDR_STAT);
  assign txPush  = regWe && (regAddr == ADDR_TXD);
  assign txData  = regWdata[BYTE_W-1:0];
  assign rxPop   = regRe && (regAddr == ADDR_RXD);

  assign owed     = byteCnt < xchgCount;
  assign canRun   = startBit && !rxHalt && owed && (modeRecv ? !rxFull : !txEmpty);
  assign stallNow = !softClr && (phase == S_IDLE) && startBit && modeRecv
                    && !rxHalt && owed && rxFull;
  assign halfDone = !softClr && (divCnt == divisor);
  assign byteEnd  = (phase == S_HIGH) && halfDone && (bitCnt == LAST_BIT);

  always_comb begin
    stb        = '0;
    stb.load   = !softClr && (phase == S_IDLE) && canRun && !modeRecv;
    stb.sample = (phase == S_LOW) && halfDone;
    stb.shift  = (phase == S_HIGH) && halfDone && (bitCnt != LAST_BIT);
    stb.push   = byteEnd && modeRecv;
  end

  assign statSet[0] = byteEnd && ((byteCnt + CNT_ONE) == xchgCount);
  assign statSet[1] = byteEnd && !modeRecv && txEmpty;
  assign statSet[2] = stallNow;

  // host-visible registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= REG_W'(16'h0004);
      xchgCount <= '0;
      stat      <= '0;
    end else begin
      if (wrCtrl) ctrlReg <= regWdata;
      if (regWe && (regAddr == ADDR_COUNT)) xchgCount <= regWdata[CNT_W-1:0];
      for (int i = 0; i < 3; i++) begin
        if (statSet[i])  stat[i] <= 1'b1;
        else if (rdStat) stat[i] <= 1'b0;
      end
    end
  end

  // serial sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= S_IDLE;
      byteCnt <= '0;
      bitCnt  <= '0;
      divCnt  <= '0;
      sckR    <= 1'b0;
      rxHalt  <= 1'b0;
    end else if (softClr) begin
      phase   <= S_IDLE;
      byteCnt <= '0;
      bitCnt  <= '0;
      divCnt  <= '0;
      sckR    <= 1'b0;
      rxHalt  <= 1'b0;
    end else begin
      case (phase)
        S_IDLE: begin
          if (canRun) begin
            phase  <= S_LOW;
            divCnt <= '0;
            bitCnt <= '0;
          end else if (stallNow) begin
            rxHalt <= 1'b1;
          end
        end
        S_LOW: begin
          if (halfDone) begin
            divCnt <= '0;
            sckR   <= 1'b1;
            phase  <= S_HIGH;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        S_HIGH: begin
          if (halfDone) begin
            divCnt <= '0;
            sckR   <= 1'b0;
            if (bitCnt == LAST_BIT) begin
              phase   <= S_IDLE;
              byteCnt <= byteCnt + CNT_ONE;
            end else begin
              bitCnt <= bitCnt + 1'b1;
              phase  <= S_LOW;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: phase <= S_IDLE;
      endcase
      if (restart) rxHalt <= 1'b0;
    end
  end

  assign sck = sckR;
  assign irq = |(stat & statEn);

  always_comb begin
    case (regAddr)
      ADDR_CTRL:  regRdata = ctrlReg;
      ADDR_COUNT: regRdata = REG_W'(xchgCount);
      ADDR_RXD:   regRdata = REG_W'(rxData);
      ADDR_STAT:  regRdata = REG_W'({!rxEmpty, txFull, stat});
      default:    regRdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_xchg_top.sv
module spi_xchg_top
  import spi_xchg_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 10,
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic        regRe,
  input  logic [2:0]  regAddr,
  input  logic [15:0] regWdata,
  output logic [15:0] regRdata,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic        csN,
  output logic        irq
);
  xchgStrobe_t       stb;
  logic              modeRecv, txPush, rxPop;
  logic              txEmpty, txFull, rxEmpty, rxFull;
  logic [BYTE_W-1:0] txData, rxData;

  spi_xchg_ctrl #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .rxData(rxData),
    .txEmpty(txEmpty), .txFull(txFull), .rxEmpty(rxEmpty), .rxFull(rxFull),
    .stb(stb), .modeRecv(modeRecv), .txPush(txPush), .txData(txData),
    .rxPop(rxPop), .sck(sck), .csN(csN), .irq(irq)
  );

  spi_xchg_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .modeRecv(modeRecv), .miso(miso),
    .txPush(txPush), .txData(txData), .rxPop(rxPop), .mosi(mosi),
    .rxData(rxData), .txEmpty(txEmpty), .txFull(txFull),
    .rxEmpty(rxEmpty), .rxFull(rxFull)
  );
endmodule

// File: rtl/spi_xchg_chk.sv
module spi_xchg_chk
  import spi_xchg_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        sck,
  input logic        mosi,
  input logic        modeRecv,
  input xchgStrobe_t stb,
  input logic        txEmpty,
  input logic        rxFull
);
  // R4
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sck && $past(sck)) |-> $stable(mosi));

  // R6
  recv_mosi_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeRecv |-> mosi);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.push |-> !rxFull);

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |-> !txEmpty);

  // R6
  push_in_recv_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.push |-> modeRecv);
endmodule

bind spi_xchg_top spi_xchg_chk u_chk (
  .clk(clk), .rstN(rstN), .sck(sck), .mosi(mosi), .modeRecv(modeRecv),
  .stb(stb), .txEmpty(txEmpty), .rxFull(rxFull)
);

// File: tb/spi_xchg_top_bench.sv
module spi_xchg_top_bench;
  localparam logic [2:0] A_CTRL = 3'd0, A_CNT = 3'd1, A_RST = 3'd2,
                         A_TXD = 3'd3, A_RXD = 3'd4, A_STAT = 3'd5;

  typedef struct packed {
    logic [7:0] div;
    logic [7:0] txb;
    logic [7:0] seed;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{8'd0, 8'hA5, 8'h3C},
    '{8'd1, 8'h81, 8'hF0},
    '{8'd3, 8'h5E, 8'h01},
    '{8'd6, 8'h00, 8'hC9}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0, regRe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        sck, mosi, miso, csN, irq;

  int nChecks = 0, nFails = 0;
  int cyc = 0, lastRise = 0, lastGap = 0, riseCnt = 0;
  int capN = 0, bitPos = 0, mosiZero = 0, cardBit = 0;
  logic [7:0] capSh = '0;
  logic [7:0] capBytes [32];
  logic [7:0] seed = '0;
  logic       recvExpect = 1'b0;
  logic [15:0] rd;

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  spi_xchg_top u_spi_xchg_top (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sck(sck), .mosi(mosi),
    .miso(miso), .csN(csN), .irq(irq)
  );

  function automatic logic [7:0] cardByte(input int k);
    logic [7:0] kk;
    kk = 8'(k * 29);
    return seed ^ kk;
  endfunction

  // card model: shifts its reply on falling edges, MSB first
  always_comb begin
    logic [7:0] b;
    b = cardByte(cardBit / 8);
    miso = b[7 - (cardBit % 8)];
  end
  always @(negedge sck) cardBit++;

  // monitor of the serial line
  always @(posedge sck) begin
    riseCnt++;
    if (bitPos != 0) lastGap = cyc - lastRise;
    lastRise = cyc;
    if (recvExpect && !mosi) mosiZero++;
    capSh = {capSh[6:0], mosi};
    bitPos++;
    if (bitPos == 8) begin
      if (capN < 32) capBytes[capN] = capSh;
      capN++;
      bitPos = 0;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic regWr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    regRe = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRe = 1'b0;
  endtask

  task automatic waitIrq(input string tag, input int maxCyc);
    int n;
    n = 0;
    while (!irq && n < maxCyc) begin
      @(negedge clk);
      n++;
    end
    if (!irq) begin
      nChecks++; nFails++;
      $display("FAIL %s: actual irq 0 expected irq 1 (timeout)", tag);
    end
  endtask

  task automatic quiet(input string tag, input int n);
    int r0;
    r0 = riseCnt;
    repeat (n) @(negedge clk);
    check(tag, riseCnt - r0, 0);
  endtask

  task automatic newXchg();
    regWr(A_CTRL, 16'h0100);
    regWr(A_RST, 16'h0000);
    capN = 0; bitPos = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 csN", csN, 1);
    check("R1 sck", sck, 0);
    check("R1 mosi", mosi, 1);
    check("R1 irq", irq, 0);
    regRd(A_STAT, rd); check("R1 status", rd[2:0], 0);
    regRd(A_CTRL, rd); check("R1 ctrl", rd, 16'h0004);

    // R2 chip select level
    regWr(A_CTRL, 16'h0000); check("R2 csN low", csN, 0);
    regWr(A_CTRL, 16'h0004); check("R2 csN high", csN, 1);

    // R12 no start, no clock
    regWr(A_RST, 0); regWr(A_CNT, 4);
    regWr(A_CTRL, 16'h0102);
    quiet("R12 no sck without start", 80);

    // table: one send and one receive byte per divisor
    for (int v = 0; v < 4; v++) begin
      newXchg();
      regWr(A_CNT, 1);
      regWr(A_TXD, {8'h00, VEC[v].txb});
      lastGap = 0;
      regWr(A_CTRL, {VEC[v].div, 8'h09});
      waitIrq("R5 table send", 2000);
      regRd(A_STAT, rd); check("R5 table send status", rd[2:0], 3'b011);
      check("R4 table byte count", capN, 1);
      check("R4 table mosi byte", capBytes[0], VEC[v].txb);
      check("R3 table sck period", lastGap, 2 * (VEC[v].div + 1));

      newXchg();
      seed = VEC[v].seed; cardBit = 0; recvExpect = 1'b1;
      regWr(A_CTRL, {VEC[v].div, 8'h0B});
      waitIrq("R7 table recv", 2000);
      regRd(A_STAT, rd); check("R7 table recv status", rd[2:0], 3'b001);
      regRd(A_RXD, rd); check("R6 table rx byte", rd[7:0], cardByte(0));
      recvExpect = 1'b0;
    end

    // R5 six-byte command
    newXchg();
    regWr(A_CNT, 6);
    for (int k = 0; k < 6; k++) regWr(A_TXD, 16'(8'h40 + k * 7));
    regWr(A_CTRL, 16'h0109);
    waitIrq("R5 six send", 4000);
    regRd(A_STAT, rd); check("R5 six status", rd[2:0], 3'b011);
    check("R5 six count", capN, 6);
    for (int k = 0; k < 6; k++) check("R4 six byte order", capBytes[k], 8'(8'h40 + k * 7));

    // R5 count below queue level: txEmpty stays clear
    newXchg();
    regWr(A_CNT, 2);
    regWr(A_TXD, 16'h0011); regWr(A_TXD, 16'h0022); regWr(A_TXD, 16'h0033);
    regWr(A_CTRL, 16'h0109);
    waitIrq("R5 partial send", 4000);
    regRd(A_STAT, rd); check("R5 partial status", rd[2:0], 3'b001);
    check("R5 partial count", capN, 2);
    quiet("R7 send stops at count", 60);
    regWr(A_CTRL, 16'h0108);
    regWr(A_RST, 0); regWr(A_CNT, 1);
    regWr(A_CTRL, 16'h0109);
    waitIrq("R5 leftover send", 2000);
    regRd(A_STAT, rd); check("R5 leftover status", rd[2:0], 3'b011);
    check("R5 leftover byte", capBytes[2], 8'h33);

    // R8 receive stall at full queue
    newXchg();
    regWr(A_CNT, 10);
    seed = 8'h6B; cardBit = 0; recvExpect = 1'b1;
    regWr(A_CTRL, 16'h012B);
    waitIrq("R8 stall", 4000);
    regRd(A_STAT, rd); check("R8 rxfull status", rd[2:0], 3'b100);
    quiet("R8 sck gated", 80);
    for (int k = 0; k < 8; k++) begin
      regRd(A_RXD, rd); check("R6 stall bytes", rd[7:0], cardByte(k));
    end
    regWr(A_CTRL, 16'h012B);
    waitIrq("R8 resume", 4000);
    regRd(A_STAT, rd); check("R8 resume status", rd[2:0], 3'b001);
    for (int k = 8; k < 10; k++) begin
      regRd(A_RXD, rd); check("R8 remaining bytes", rd[7:0], cardByte(k));
    end
    check("R8 total sck rises", capN, 10);
    quiet("R7 recv stops at count", 60);

    // R11 soft reset: nonzero ignored, zero restarts
    regWr(A_RST, 16'h0005);
    quiet("R11 nonzero write ignored", 60);
    cardBit = 0; capN = 0; bitPos = 0;
    regWr(A_RST, 16'h0000);
    waitIrq("R11 restart", 4000);
    regRd(A_STAT, rd); check("R11 restart status", rd[2:0], 3'b100);
    check("R11 restart byte count", capN, 8);
    regRd(A_RXD, rd); check("R11 restart first byte", rd[7:0], cardByte(0));
    regWr(A_CTRL, 16'h0108);
    regWr(A_RST, 0);
    for (int k = 1; k < 8; k++) regRd(A_RXD, rd);
    recvExpect = 1'b0;

    // R9 / R10 masking and clear-on-read
    newXchg();
    regWr(A_CNT, 1);
    seed = 8'h99; cardBit = 0;
    regWr(A_CTRL, 16'h0103);
    repeat (80) @(negedge clk);
    check("R9 masked irq", irq, 0);
    regWr(A_CTRL, 16'h010B);
    check("R9 enabled irq", irq, 1);
    regRd(A_STAT, rd); check("R10 first read", rd[2:0], 3'b001);
    regRd(A_STAT, rd); check("R10 second read", rd[2:0], 3'b000);
    check("R9 irq after clear", irq, 0);
    regRd(A_RXD, rd); check("R6 single byte", rd[7:0], cardByte(0));

    check("R6 mosi high in receive", mosiZero, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule